// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block derives the serial clock of an SPI master port from the system clock through an 8-bit programmable divider. It also emits single-cycle sample and shift strobes for a neighbouring shift register. Each half period of the serial clock lasts divider-plus-one system cycles, so the serial clock runs at the system clock divided by twice that amount. A divider of zero gives half the system clock. The polarity input picks the idle level and therefore which edge is active. The phase input picks whether data is sampled on the active or the inactive edge.

A transfer begins on a rising edge of `enable`. It runs for the programmed number of bits and returns the clock to idle. It then reports completion with a one-cycle `done` pulse. The divider sits in a 16-bit bus register whose upper byte always reads as zero. The divider value and the mode bits are captured when a transfer starts, so changes made while busy apply to the next transfer. A separate monitor watches an externally driven serial clock in slave mode. It flags any edge spacing faster than one-eighth of the system clock.

Top module: `spi_sclk_gen`

## Requirements
- R1: After synchronous reset `regRdData` is 0, `busy`, `done`, `sampleStb`, `shiftStb` and `rateFault` are 0, and `sclk` sits at the level of `cpol`.
- R2: A bus write stores `regWrData[7:0]` as the divider. `regRdData[7:0]` returns the stored divider, and `regRdData[15:8]` always reads 0 whatever is written.
- R3: During a transfer with divider D (0..255), `sclk` toggles every D+1 system cycles, so D=0 gives half the system clock.
- R4: While idle, `sclk` equals `cpol` (0 idles low with rising as the active edge, 1 idles high with falling as the active edge). A transfer of N bits starts at the idle level, the first toggle comes D+1 cycles after the start edge, and exactly 2N toggles (N full periods) follow.
- R5: `busy` is 1 from the cycle after the clock edge that sees `enable` rise, and stays 1 for 2N(D+1) cycles. `done` is 1 for exactly one cycle, the first cycle with `busy` back at 0.
- R6: With `cpha`=0, `sampleStb` pulses in the cycle after each odd-numbered (active) toggle. `shiftStb` pulses in the first busy cycle and after each even-numbered toggle except the last.
- R7: With `cpha`=1, `shiftStb` pulses after each odd-numbered toggle and `sampleStb` pulses after each even-numbered toggle, the last included.
- R8: `sampleStb` and `shiftStb` are never high together and only appear while `busy` or `done` is high. Each transfer gives exactly N of each.
- R9: Divider writes and changes of `cpol` or `cpha` while busy do not alter the running transfer. They apply from the next transfer, and the idle level follows `cpol` again after `done`.
- R10: A rising edge of `enable` while busy is ignored, holding `enable` high after `done` does not restart, and dropping `enable` mid-transfer does not abort.
- R11: A start with `bitCount`=0 gives a `done` pulse in the cycle after the start edge with no `busy` and no `sclk` toggle.
- R12: With `slaveMode`=1, `rateFault` pulses for one cycle whenever two successive edges of `extSclk` are fewer than 4 system cycles apart (edges are measured after a 2-stage synchronizer). With `slaveMode`=0, or with spacing of 4 or more, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Divider register write strobe |
| regWrData | input | 16 | Divider register write data |
| regRdData | output | 16 | Divider register read-back |
| cpol | input | 1 | Clock polarity select (idle level) |
| cpha | input | 1 | Clock phase select (0 sample on active edge) |
| enable | input | 1 | Rising edge starts a transfer |
| bitCount | input | 6 | Transfer length in bits |
| sclk | output | 1 | Serial clock to the bus |
| sampleStb | output | 1 | One-cycle sample strobe |
| shiftStb | output | 1 | One-cycle shift strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| slaveMode | input | 1 | Enables the external clock rate monitor |
| extSclk | input | 1 | External serial clock in slave mode |
| rateFault | output | 1 | One-cycle pulse on a too-fast external edge |

## Verification
The hardest situation to reach is a transfer whose divider and mode inputs change after it has started, combined with `enable` being toggled while it runs. The stimulus drives a new divider and flips both mode bits one cycle into selected transfers. It also drops and re-raises `enable` mid-transfer. It then compares every cycle of `sclk`, the strobes, `busy` and `done` with a timeline computed from the values captured at the start. The random transfers draw dividers, lengths and modes from a seeded generator. Directed cases cover divider 0, divider 255 and zero length.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  // control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture divider/polarity, start half-period timing
    logic run;    // transfer in progress
  } ctlStb_t;

endpackage

// File: rtl/sclk_datapath.sv
module sclk_datapath
  import sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStb_t          ctl,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             cpol,
  output logic [REG_W-1:0] regRdData,
  output logic             sclk,
  output logic             halfTick
);

  localparam int PAD_W = REG_W - DIV_W;

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divLat;
  logic [DIV_W-1:0] halfCnt;
  logic             sclkQ;

  // bus-visible divider; upper bits are not stored
  always_ff @(posedge clk) begin
    if (rst) begin
      divReg <= '0;
    end else if (regWrEn) begin
      divReg <= regWrData[DIV_W-1:0];
    end
  end

  assign regRdData = {{PAD_W{1'b0}}, divReg};

  // half-period timer: reaches zero once every divLat+1 cycles
  assign halfTick = ctl.run && (halfCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      divLat  <= '0;
      halfCnt <= '0;
      sclkQ   <= cpol;
    end else if (ctl.load) begin
      divLat  <= divReg;
      halfCnt <= divReg;
      sclkQ   <= cpol;
    end else if (ctl.run) begin
      if (halfCnt == '0) begin
        halfCnt <= divLat;
        sclkQ   <= ~sclkQ;
      end else begin
        halfCnt <= halfCnt - 1'b1;
      end
    end else begin
      sclkQ <= cpol;
    end
  end

  assign sclk = sclkQ;

endmodule

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import sclk_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             cpha,
  input  logic [LEN_W-1:0] bitCount,
  input  logic             halfTick,
  output ctlStb_t          ctl,
  output logic             sampleStb,
  output logic             shiftStb,
  output logic             busy,
  output logic             done
);

  localparam int EDGE_W = LEN_W + 1;

  logic              enPrev;
  logic              busyQ;
  logic              doneQ;
  logic              sampQ;
  logic              shiftQ;
  logic              phaLat;
  logic [LEN_W-1:0]  lenLat;
  logic [EDGE_W-1:0] edgeIdx;
  logic [EDGE_W-1:0] edgeNum;
  logic [EDGE_W-1:0] edgeLast;
  logic              startReq;
  logic              isOdd;
  logic              isLast;

  assign startReq = enable && !enPrev && !busyQ;
  assign edgeNum  = edgeIdx + 1'b1;
  assign edgeLast = {lenLat, 1'b0};
  assign isOdd    = edgeNum[0];
  assign isLast   = (edgeNum == edgeLast);

  always_comb begin
    ctl.load = startReq && (bitCount != '0);
    ctl.run  = busyQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enPrev  <= 1'b0;
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      sampQ   <= 1'b0;
      shiftQ  <= 1'b0;
      phaLat  <= 1'b0;
      lenLat  <= '0;
      edgeIdx <= '0;
    end else begin
      enPrev <= enable;
      doneQ  <= 1'b0;
      sampQ  <= 1'b0;
      shiftQ <= 1'b0;
      if (startReq) begin
        if (bitCount == '0) begin
          doneQ <= 1'b1;
        end else begin
          busyQ   <= 1'b1;
          phaLat  <= cpha;
          lenLat  <= bitCount;
          edgeIdx <= '0;
          shiftQ  <= !cpha;   // phase 0 presents the first bit before any edge
        end
      end else if (busyQ && halfTick) begin
        edgeIdx <= edgeNum;
        if (phaLat) begin
          shiftQ <= isOdd;
          sampQ  <= !isOdd;
        end else begin
          sampQ  <= isOdd;
          shiftQ <= !isOdd && !isLast;
        end
        if (isLast) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign sampleStb = sampQ;
  assign shiftStb  = shiftQ;
  assign busy      = busyQ;
  assign done      = doneQ;

endmodule

// File: rtl/sclk_rate_mon.sv
module sclk_rate_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HALF    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic slaveMode,
  input  logic extSclk,
  output logic rateFault
);

  localparam int GAP_W = $clog2(MIN_HALF) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(MIN_HALF);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   seenQ;
  logic                   faultQ;
  logic [GAP_W-1:0]       sinceEdge;
  logic                   edgeSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extSclk};
    end
  end

  assign edgeSeen = syncQ[SYNC_STAGES-1] ^ prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ     <= 1'b0;
      seenQ     <= 1'b0;
      faultQ    <= 1'b0;
      sinceEdge <= '0;
    end else begin
      prevQ  <= syncQ[SYNC_STAGES-1];
      faultQ <= 1'b0;
      if (edgeSeen) begin
        sinceEdge <= GAP_W'(1);
        faultQ    <= slaveMode && seenQ && (sinceEdge < GAP_MIN);
      end else if (sinceEdge != GAP_MAX) begin
        sinceEdge <= sinceEdge + 1'b1;
      end
      if (!slaveMode) begin
        seenQ <= 1'b0;
      end else if (edgeSeen) begin
        seenQ <= 1'b1;
      end
    end
  end

  assign rateFault = faultQ;

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import sclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int REG_W       = 16,
  parameter int LEN_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HALF    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             enable,
  input  logic [LEN_W-1:0] bitCount,
  output logic             sclk,
  output logic             sampleStb,
  output logic             shiftStb,
  output logic             busy,
  output logic             done,
  input  logic             slaveMode,
  input  logic             extSclk,
  output logic             rateFault
);

  ctlStb_t ctl;
  logic    halfTick;

  sclk_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .cpha      (cpha),
    .bitCount  (bitCount),
    .halfTick  (halfTick),
    .ctl       (ctl),
    .sampleStb (sampleStb),
    .shiftStb  (shiftStb),
    .busy      (busy),
    .done      (done)
  );

  sclk_datapath #(.DIV_W(DIV_W), .REG_W(REG_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .cpol      (cpol),
    .regRdData (regRdData),
    .sclk      (sclk),
    .halfTick  (halfTick)
  );

  sclk_rate_mon #(.SYNC_STAGES(SYNC_STAGES), .MIN_HALF(MIN_HALF)) u_rate (
    .clk       (clk),
    .rst       (rst),
    .slaveMode (slaveMode),
    .extSclk   (extSclk),
    .rateFault (rateFault)
  );

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int REG_W = 16,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] regRdData,
  input logic             cpol,
  input logic             sclk,
  input logic             sampleStb,
  input logic             shiftStb,
  input logic             busy,
  input logic             done,
  input logic             slaveMode,
  input logic             rateFault
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !sampleStb && !shiftStb && !rateFault && regRdData == '0));

  assert_rd_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    regRdData[REG_W-1:DIV_W] == '0);

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (sclk == $past(cpol)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(sampleStb && shiftStb));

  assert_strobe_in_xfer_R8: assert property (@(posedge clk) disable iff (rst)
    (sampleStb || shiftStb) |-> (busy || done));

  assert_fault_mode_R12: assert property (@(posedge clk) disable iff (rst)
    rateFault |-> $past(slaveMode));

  assert_fault_single_R12: assert property (@(posedge clk) disable iff (rst)
    rateFault |=> !rateFault);

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regRdData (regRdData),
  .cpol      (cpol),
  .sclk      (sclk),
  .sampleStb (sampleStb),
  .shiftStb  (shiftStb),
  .busy      (busy),
  .done      (done),
  .slaveMode (slaveMode),
  .rateFault (rateFault)
);

// File: tb/spi_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_sclk_gen_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        cpol, cpha, enable;
  logic [5:0]  bitCount;
  logic        sclk, sampleStb, shiftStb, busy, done;
  logic        slaveMode, extSclk, rateFault;

  int checks = 0;
  int failures = 0;
  int faultCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_sclk_gen u_spi_sclk_gen (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .cpol(cpol), .cpha(cpha), .enable(enable),
    .bitCount(bitCount), .sclk(sclk), .sampleStb(sampleStb),
    .shiftStb(shiftStb), .busy(busy), .done(done), .slaveMode(slaveMode),
    .extSclk(extSclk), .rateFault(rateFault)
  );

  always @(negedge clk) if (rateFault) faultCnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected {sclk, sampleStb, shiftStb, busy, done} c cycles after the start edge
  function automatic logic [4:0] expVec(int c, int d, int n, bit pol, bit pha);
    int h = d + 1;
    int total = 2 * n * h;
    int m = c / h;
    int k = 0;
    bit s, smp = 0, sh = 0;
    if (m > 2 * n) m = 2 * n;
    s = pol ^ m[0];
    if (c > 0 && (c % h) == 0 && (c / h) <= 2 * n) k = c / h;
    if (c == 0) sh = !pha;
    else if (k != 0) begin
      if (pha) begin sh = k[0]; smp = !k[0]; end
      else begin smp = k[0]; sh = !k[0] && (k != 2 * n); end
    end
    return {s, smp, sh, (c < total), (c == total)};
  endfunction

  task automatic writeDiv(input logic [15:0] v);
    @(negedge clk);
    regWrData = v; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runXfer(input int d, input int n, input bit pol, input bit pha,
                         input bit midWrite, input bit toggleEn);
    int total = 2 * n * (d + 1);
    int badS = 0, badStb = 0, badBD = 0;
    int aS = 0, eS = 0, aStb = 0, eStb = 0, aBD = 0, eBD = 0;
    int nSamp = 0, nShift = 0;
    logic [4:0] e;
    writeDiv(16'(d));
    @(negedge clk);
    cpol = pol; cpha = pha; bitCount = 6'(n); enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    for (int c = 0; c <= total; c++) begin
      @(negedge clk);
      e = expVec(c, d, n, pol, pha);
      if (sclk != e[4] && badS == 0) begin badS = 1; aS = c; eS = e[4]; end
      if ({sampleStb, shiftStb} != e[3:2] && badStb == 0) begin
        badStb = 1; aStb = {sampleStb, shiftStb}; eStb = e[3:2];
      end
      if ({busy, done} != e[1:0] && badBD == 0) begin
        badBD = 1; aBD = {busy, done}; eBD = e[1:0];
      end
      nSamp += int'(sampleStb); nShift += int'(shiftStb);
      regWrEn = 1'b0;
      if (midWrite && c == 1) begin
        regWrData = 16'h00FF & 16'(d + 3); regWrEn = 1'b1;
        cpol = !pol; cpha = !pha;
      end
      if (toggleEn && total > 6) begin
        if (c == 1) enable = 1'b0;
        if (c == 3) enable = 1'b1;
      end
    end
    check(badS == 0, midWrite ? "R9 sclk waveform" : "R3 R4 sclk waveform", aS, eS);
    check(badStb == 0, pha ? "R7 strobes" : "R6 strobes", aStb, eStb);
    check(badBD == 0, toggleEn ? "R10 busy/done" : "R5 busy/done", aBD, eBD);
    check(nSamp == n && nShift == n, "R8 strobe count", nSamp * 100 + nShift, n * 101);
    if (midWrite) begin
      @(negedge clk);
      check(sclk == !pol, "R9 idle level follows new cpol", sclk, !pol);
      check(regRdData == 16'((d + 3) & 255), "R9 divider readback", regRdData, (d + 3) & 255);
    end
    if (toggleEn) begin
      int extra = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        extra += int'(busy) + int'(done);
      end
      check(extra == 0, "R10 no restart with enable held", extra, 0);
    end
    @(negedge clk);
    enable = 1'b0;
  endtask

  task automatic extToggles(input int cnt, input int gap);
    for (int i = 0; i < cnt; i++) begin
      extSclk = !extSclk;
      repeat (gap) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; regWrEn = 1'b0; regWrData = '0; cpol = 1'b1; cpha = 1'b0;
    enable = 1'b0; bitCount = '0; slaveMode = 1'b0; extSclk = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(regRdData == 0, "R1 readback after reset", regRdData, 0);
    check({busy, done, sampleStb, shiftStb, rateFault} == 0, "R1 outputs after reset",
          {busy, done, sampleStb, shiftStb, rateFault}, 0);
    check(sclk == 1'b1, "R1 sclk idle at cpol", sclk, 1);
    cpol = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(sclk == 1'b0, "R4 idle follows cpol", sclk, 0);

    // R2 upper byte discarded
    writeDiv(16'hA5C3);
    @(negedge clk);
    check(regRdData == 16'h00C3, "R2 readback upper zero", regRdData, 16'h00C3);

    // directed corners
    runXfer(0, 1, 0, 0, 0, 0);     // R3 divider 0, half system clock
    runXfer(0, 8, 1, 1, 0, 0);
    runXfer(255, 1, 0, 1, 0, 0);   // R3 maximum divider
    runXfer(2, 5, 0, 0, 1, 0);     // R9 mid-transfer changes
    runXfer(1, 4, 1, 0, 0, 1);     // R10 enable games
    runXfer(3, 63, 1, 1, 0, 0);

    // R11 zero length
    writeDiv(16'd2);
    @(negedge clk);
    bitCount = '0; cpol = 1'b1; enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(done == 1 && busy == 0 && sclk == 1, "R11 zero length done", {done, busy, sclk}, 3'b101);
    @(negedge clk);
    check(done == 0 && busy == 0 && sclk == 1, "R11 zero length quiet", {done, busy, sclk}, 3'b001);
    enable = 1'b0;

    // constrained random transfers
    for (int t = 0; t < 20; t++) begin
      runXfer(int'($urandom_range(0, 7)), int'($urandom_range(1, 9)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
    end

    // R12 slave clock rate monitor
    slaveMode = 1'b1;
    repeat (6) @(negedge clk);
    faultCnt = 0;
    extToggles(10, 4);
    check(faultCnt == 0, "R12 legal spacing no fault", faultCnt, 0);
    faultCnt = 0;
    extToggles(6, 2);
    check(faultCnt == 5, "R12 fast spacing faults", faultCnt, 5);
    slaveMode = 1'b0;
    repeat (6) @(negedge clk);
    faultCnt = 0;
    extToggles(6, 2);
    check(faultCnt == 0, "R12 monitor off in master mode", faultCnt, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule